// File: doc/BRIEF.md
# Segmented Message Record/Playback Sequencer

This block is the digital control core of a message recorder whose storage is split into a fixed number of equal segments (160 by default). The falling edge of an active-low select input captures an 8-bit address word and a direction bit. The block then runs a record or a playback pass. It steps a segment pointer once per segment-period strobe and keeps one end-of-message marker bit per segment. When a message ends, or when the array fills, it signals this on an active-low end-of-message output.

When the two top address bits are both high, the low six bits are read as option flags rather than as a start segment. The options are message cueing, looping, cascade-style end signalling, a persistent pointer for back-to-back messages, and level-controlled playback. The block also drives a select for the auxiliary audio path, a speaker-enable and activity indicators. The sample storage and the analog chain are outside this block. A single strobe marks the end of each segment period.

Top module: `msg_seg_sequencer`

## Requirements
- R1: After reset the block is idle, the segment pointer reads 0 and the end-of-message output is high. A cycle with the power-down input high aborts any pass, returns the pointer to 0, clears the overflow lock and forgets the consecutive pointer and the last direction.
- R2: A select falling edge with address bits [7:6] not both 1 and address below 160 starts a pass at that segment. The pointer output shows the address in the cycle after the edge. Direction bit 1 means playback and 0 means record.
- R3: A direct address from 160 to 191 starts no pass.
- R4: During record, each strobe advances the pointer by one. When select returns high, the marker of the current segment is set and the end-of-message output goes low for EOM_PULSE_CYC cycles.
- R5: During plain playback, a strobe at a segment without a marker advances the pointer. A strobe at a marked segment ends the pass and pulses the end-of-message output. Select going high has no effect.
- R6: A strobe at the last segment (159) without a marker, during record or playback, enters overflow. The end-of-message output stays low and further select edges are ignored until power-down is driven high.
- R7: Address bits [7:6] = 11 form a mode word whose option bits are: bit 0 cue, bit 2 cascade, bit 3 loop, bit 4 consecutive, bit 5 level. Bit 1 has no effect. A mode-word pass starts at segment 0 unless the consecutive option is set.
- R8: Loop option: a strobe at a marked segment returns the pointer to the pass start, pulses the end-of-message output, and playback continues.
- R9: Cascade option: a marker ends playback without any end-of-message pulse.
- R10: Consecutive option: a pass starts at the segment after the end of the previous consecutive pass. The start returns to 0 when the direction differs from the previous pass.
- R11: Cue option in playback: the speaker enable is low while the pointer advances. The pass stops at the next marked segment, and the pointer stays there.
- R12: Level option: playback ends, with no end-of-message pulse, in the cycle after select is seen high.
- R13: The auxiliary select is high when select is high and no pass runs, or during overflow. It is low during a playback pass even with select high.
- R14: Recording clears the marker of every segment it enters, so later playback runs through stale markers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down_i | input | 1 | Power-down; resets pass, pointer and overflow lock |
| cs_n_i | input | 1 | Active-low select; falling edge starts a pass |
| play_sel_i | input | 1 | Direction captured at the edge: 1 playback, 0 record |
| addr_i | input | 8 | Start segment or mode word |
| seg_tick_i | input | 1 | One-cycle strobe marking the end of a segment period |
| eom_n_o | output | 1 | Active-low end-of-message / overflow indication |
| aux_sel_o | output | 1 | Routes the auxiliary input to the speaker path |
| spk_en_o | output | 1 | Speaker output enabled (audible playback) |
| rec_active_o | output | 1 | Record pass running |
| play_active_o | output | 1 | Playback or cue pass running |
| seg_ptr_o | output | 8 | Current segment pointer |

## Verification
Playback passes are started directly, by mode word, and by the consecutive pointer. This shows whether the start comes from the address, is forced to zero, or is carried over from the previous pass. The same marker layout is replayed under the plain, cascade, loop+level and cue options, which separates the pulse, the silence, the wrap-around and the quiet stop. Recording over an older marker and running into the last segment in both directions checks that markers are cleared and that overflow locks until power-down. Out-of-range addresses and select edges during overflow confirm that such input is ignored.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REC  = 3'd1,
    ST_PLAY = 3'd2,
    ST_CUE  = 3'd3,
    ST_OVF  = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic level;
    logic consec;
    logic loop;
    logic cascade;
    logic cue;
  } mode_opts_t;

endpackage

// File: rtl/mseq_cmd_capture.sv
module mseq_cmd_capture
  import mseq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NSEG   = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              play_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              start_o,
  output logic              dir_play_o,
  output logic              is_mode_o,
  output mode_opts_t        mode_o,
  output logic [ADDR_W-1:0] start_seg_o
);

  logic cs_q;
  logic cs_fall;
  logic in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n_i;
  end

  assign cs_fall   = cs_q & ~cs_n_i;
  assign is_mode_o = addr_i[ADDR_W-1] & addr_i[ADDR_W-2];
  assign in_range  = {1'b0, addr_i} < (ADDR_W+1)'(NSEG);

  always_comb begin
    mode_o.cue     = addr_i[0];
    mode_o.cascade = addr_i[2];
    mode_o.loop    = addr_i[3];
    mode_o.consec  = addr_i[4];
    mode_o.level   = addr_i[5];
  end

  assign start_seg_o = addr_i;
  assign dir_play_o  = play_sel_i;
  assign start_o     = cs_fall & (is_mode_o | in_range);

  // two starts never come in adjacent cycles: an edge needs select high first
  p_single_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

endmodule

// File: rtl/mseq_flag_store.sv
module mseq_flag_store #(
  parameter int NSEG  = 160,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_o
);

  logic [NSEG-1:0] flag_q;
  logic [NSEG-1:0] flag_d;

  for (genvar g = 0; g < NSEG; g++) begin : g_mark
    logic hit;
    assign hit       = (wr_idx_i == IDX_W'(g));
    assign flag_d[g] = (hit && set_en_i) ? 1'b1 :
                       (hit && clr_en_i) ? 1'b0 : flag_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign rd_o = ({1'b0, rd_idx_i} < (IDX_W+1)'(NSEG)) ? flag_q[rd_idx_i] : 1'b0;

  // a marker written at the end of a record is readable the next cycle
  p_mark_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en_i && ({1'b0, wr_idx_i} < (IDX_W+1)'(NSEG))) |=> flag_q[$past(wr_idx_i)]);

  // a cleared marker is gone the next cycle
  p_mark_cleared_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && !set_en_i && ({1'b0, wr_idx_i} < (IDX_W+1)'(NSEG))) |=> !flag_q[$past(wr_idx_i)]);

endmodule

// File: rtl/mseq_eom_pulse.sv
module mseq_eom_pulse #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic hold_i,
  output logic eom_n_o
);

  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)             cnt_d = CNT_W'(PULSE_CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign eom_n_o = ~((cnt_q != '0) | hold_i);

  p_pulse_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !eom_n_o);

endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
#(
  parameter int NSEG  = 160,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down_i,
  input  logic             cs_n_i,
  input  logic             seg_tick_i,
  input  logic             start_i,
  input  logic             dir_play_i,
  input  logic             is_mode_i,
  input  mode_opts_t       mode_i,
  input  logic [IDX_W-1:0] start_seg_i,
  input  logic             flag_rd_i,
  output logic             flag_set_o,
  output logic             flag_clr_o,
  output logic [IDX_W-1:0] flag_wr_idx_o,
  output logic [IDX_W-1:0] ptr_o,
  output seq_state_t       state_o,
  output logic             pulse_load_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NSEG - 1);

  seq_state_t       state_q, state_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] op_start_q, op_start_d;
  logic [IDX_W-1:0] cons_q, cons_d;
  logic             last_dir_q, last_dir_d;
  logic             dir_vld_q, dir_vld_d;
  mode_opts_t       mode_q, mode_d;

  logic [IDX_W-1:0] base;
  logic [IDX_W-1:0] ptr_inc;
  logic [IDX_W-1:0] after_end;

  assign ptr_inc   = ptr_q + 1'b1;
  assign after_end = (ptr_q == LAST) ? '0 : ptr_inc;

  always_comb begin
    if (!is_mode_i)
      base = start_seg_i;
    else if (mode_i.consec)
      base = (dir_vld_q && (last_dir_q != dir_play_i)) ? '0 : cons_q;
    else
      base = '0;
  end

  always_comb begin
    state_d       = state_q;
    ptr_d         = ptr_q;
    op_start_d    = op_start_q;
    cons_d        = cons_q;
    last_dir_d    = last_dir_q;
    dir_vld_d     = dir_vld_q;
    mode_d        = mode_q;
    flag_set_o    = 1'b0;
    flag_clr_o    = 1'b0;
    flag_wr_idx_o = ptr_q;
    pulse_load_o  = 1'b0;

    if (pwr_down_i) begin
      state_d    = ST_IDLE;
      ptr_d      = '0;
      op_start_d = '0;
      cons_d     = '0;
      dir_vld_d  = 1'b0;
      mode_d     = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            ptr_d      = base;
            op_start_d = base;
            last_dir_d = dir_play_i;
            dir_vld_d  = 1'b1;
            mode_d     = is_mode_i ? mode_i : '0;
            if (is_mode_i && mode_i.consec) cons_d = base;
            if (!dir_play_i) begin
              state_d       = ST_REC;
              flag_clr_o    = 1'b1;
              flag_wr_idx_o = base;
            end else if (is_mode_i && mode_i.cue) begin
              state_d = ST_CUE;
            end else begin
              state_d = ST_PLAY;
            end
          end
        end
        ST_REC: begin
          if (cs_n_i) begin
            flag_set_o   = 1'b1;
            pulse_load_o = 1'b1;
            state_d      = ST_IDLE;
            if (mode_q.consec) cons_d = after_end;
          end else if (seg_tick_i) begin
            if (ptr_q == LAST) begin
              state_d = ST_OVF;
            end else begin
              ptr_d         = ptr_inc;
              flag_clr_o    = 1'b1;
              flag_wr_idx_o = ptr_inc;
            end
          end
        end
        ST_PLAY: begin
          if (mode_q.level && cs_n_i) begin
            state_d = ST_IDLE;
          end else if (seg_tick_i) begin
            if (flag_rd_i) begin
              pulse_load_o = ~mode_q.cascade;
              if (mode_q.loop) begin
                ptr_d = op_start_q;
              end else begin
                state_d = ST_IDLE;
                if (mode_q.consec) cons_d = after_end;
              end
            end else if (ptr_q == LAST) begin
              state_d = ST_OVF;
            end else begin
              ptr_d = ptr_inc;
            end
          end
        end
        ST_CUE: begin
          if (seg_tick_i) begin
            if (flag_rd_i) begin
              state_d = ST_IDLE;
              if (mode_q.consec) cons_d = after_end;
            end else if (ptr_q == LAST) begin
              state_d = ST_OVF;
            end else begin
              ptr_d = ptr_inc;
            end
          end
        end
        ST_OVF: ;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ptr_q      <= '0;
      op_start_q <= '0;
      cons_q     <= '0;
      last_dir_q <= 1'b0;
      dir_vld_q  <= 1'b0;
      mode_q     <= '0;
    end else begin
      state_q    <= state_d;
      ptr_q      <= ptr_d;
      op_start_q <= op_start_d;
      cons_q     <= cons_d;
      last_dir_q <= last_dir_d;
      dir_vld_q  <= dir_vld_d;
      mode_q     <= mode_d;
    end
  end

  assign ptr_o   = ptr_q;
  assign state_o = state_q;

  p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ptr_q} < (IDX_W+1)'(NSEG));

  p_rec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REC && !cs_n_i && seg_tick_i && ptr_q != LAST && !pwr_down_i)
      |=> (ptr_q == $past(ptr_q) + 1'b1));

  p_play_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PLAY && seg_tick_i && flag_rd_i && !mode_q.loop && !pwr_down_i)
      |=> (state_q == ST_IDLE));

  p_ovf_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OVF && !pwr_down_i) |=> (state_q == ST_OVF));

  p_pwr_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_i |=> (state_q == ST_IDLE && ptr_q == '0));

endmodule

// File: rtl/msg_seg_sequencer.sv
module msg_seg_sequencer
  import mseq_pkg::*;
#(
  parameter int NSEG          = 160,
  parameter int ADDR_W        = 8,
  parameter int EOM_PULSE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down_i,
  input  logic              cs_n_i,
  input  logic              play_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              seg_tick_i,
  output logic              eom_n_o,
  output logic              aux_sel_o,
  output logic              spk_en_o,
  output logic              rec_active_o,
  output logic              play_active_o,
  output logic [ADDR_W-1:0] seg_ptr_o
);

  localparam int IDX_W = ADDR_W;

  logic             start;
  logic             dir_play;
  logic             is_mode;
  mode_opts_t       mode;
  logic [IDX_W-1:0] start_seg;
  logic             flag_rd;
  logic             flag_set;
  logic             flag_clr;
  logic [IDX_W-1:0] flag_wr_idx;
  logic [IDX_W-1:0] ptr;
  seq_state_t       state;
  logic             pulse_load;
  logic             ovf;

  mseq_cmd_capture #(.ADDR_W(ADDR_W), .NSEG(NSEG)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_i      (cs_n_i),
    .play_sel_i  (play_sel_i),
    .addr_i      (addr_i),
    .start_o     (start),
    .dir_play_o  (dir_play),
    .is_mode_o   (is_mode),
    .mode_o      (mode),
    .start_seg_o (start_seg)
  );

  mseq_ctrl #(.NSEG(NSEG), .IDX_W(IDX_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_down_i    (pwr_down_i),
    .cs_n_i        (cs_n_i),
    .seg_tick_i    (seg_tick_i),
    .start_i       (start),
    .dir_play_i    (dir_play),
    .is_mode_i     (is_mode),
    .mode_i        (mode),
    .start_seg_i   (start_seg),
    .flag_rd_i     (flag_rd),
    .flag_set_o    (flag_set),
    .flag_clr_o    (flag_clr),
    .flag_wr_idx_o (flag_wr_idx),
    .ptr_o         (ptr),
    .state_o       (state),
    .pulse_load_o  (pulse_load)
  );

  mseq_flag_store #(.NSEG(NSEG), .IDX_W(IDX_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en_i (flag_set),
    .clr_en_i (flag_clr),
    .wr_idx_i (flag_wr_idx),
    .rd_idx_i (ptr),
    .rd_o     (flag_rd)
  );

  assign ovf = (state == ST_OVF);

  mseq_eom_pulse #(.PULSE_CYC(EOM_PULSE_CYC)) u_eom (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (pulse_load),
    .hold_i  (ovf),
    .eom_n_o (eom_n_o)
  );

  assign seg_ptr_o     = ptr;
  assign rec_active_o  = (state == ST_REC);
  assign play_active_o = (state == ST_PLAY) || (state == ST_CUE);
  assign spk_en_o      = (state == ST_PLAY);
  assign aux_sel_o     = (cs_n_i && state == ST_IDLE) || ovf;

  // overflow keeps the end-of-message line low until power-down
  p_ovf_eom_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !pwr_down_i) |=> !eom_n_o);

endmodule

// File: tb/msg_seg_sequencer_tb.sv
`timescale 1ns/100ps
module msg_seg_sequencer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwr_down;
  logic       cs_n;
  logic       play_sel;
  logic [7:0] addr;
  logic       seg_tick;
  logic       eom_n, aux_sel, spk_en, rec_act, play_act;
  logic [7:0] seg_ptr;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  msg_seg_sequencer dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_down_i    (pwr_down),
    .cs_n_i        (cs_n),
    .play_sel_i    (play_sel),
    .addr_i        (addr),
    .seg_tick_i    (seg_tick),
    .eom_n_o       (eom_n),
    .aux_sel_o     (aux_sel),
    .spk_en_o      (spk_en),
    .rec_active_o  (rec_act),
    .play_active_o (play_act),
    .seg_ptr_o     (seg_ptr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) cyc();
  endtask

  task automatic start_op(input logic [7:0] a, input logic sel);
    cs_n = 1'b1; cyc();
    addr = a; play_sel = sel; cs_n = 1'b0; cyc();
  endtask

  task automatic tick(input int n);
    repeat (n) begin seg_tick = 1'b1; cyc(); seg_tick = 1'b0; end
  endtask

  task automatic pdown();
    pwr_down = 1'b1; cyc(); pwr_down = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ptr after reset", seg_ptr, 0);
    chk("R1 eom_n after reset", eom_n, 1);
    chk("R1 idle after reset", rec_act | play_act, 0);
    chk("R13 aux idle cs high", aux_sel, 1);
  endtask

  task automatic t_record_direct();
    start_op(8'd10, 1'b0);
    chk("R2 record active", rec_act, 1);
    chk("R2 start pointer", seg_ptr, 10);
    chk("R13 aux low in record", aux_sel, 0);
    tick(2);
    chk("R4 pointer steps", seg_ptr, 12);
    cs_n = 1'b1; cyc();
    chk("R4 record ends", rec_act, 0);
    chk("R4 pulse first cycle", eom_n, 0);
    idle(3);
    chk("R4 pulse last cycle", eom_n, 0);
    cyc();
    chk("R4 pulse over", eom_n, 1);
  endtask

  task automatic t_play_direct();
    start_op(8'd10, 1'b1);
    chk("R2 play active", play_act, 1);
    chk("R13 speaker on", spk_en, 1);
    cs_n = 1'b1; cyc();
    chk("R5 select high ignored", play_act, 1);
    chk("R13 aux low while playing", aux_sel, 0);
    tick(2);
    chk("R5 ptr at marker", seg_ptr, 12);
    chk("R5 still playing", play_act, 1);
    tick(1);
    chk("R5 stops at marker", play_act, 0);
    chk("R5 marker pulse", eom_n, 0);
    chk("R13 aux after playback", aux_sel, 1);
    idle(6);
  endtask

  task automatic t_out_of_range();
    start_op(8'd170, 1'b0);
    chk("R3 no record", rec_act, 0);
    start_op(8'd191, 1'b1);
    chk("R3 no playback", play_act, 0);
    chk("R3 ptr unchanged", seg_ptr, 12);
    cs_n = 1'b1; cyc();
  endtask

  task automatic t_cascade();
    start_op(8'hC4, 1'b1);
    chk("R7 mode word starts at 0", seg_ptr, 0);
    tick(12);
    chk("R9 reached marker", seg_ptr, 12);
    tick(1);
    chk("R9 playback ended", play_act, 0);
    chk("R9 no marker pulse", eom_n, 1);
    cs_n = 1'b1; idle(3);
  endtask

  task automatic t_loop_level();
    start_op(8'hE8, 1'b1);
    tick(13);
    chk("R8 wraps to start", seg_ptr, 0);
    chk("R8 keeps playing", play_act, 1);
    chk("R8 marker pulse", eom_n, 0);
    cs_n = 1'b1; cyc();
    chk("R12 level stop", play_act, 0);
    idle(6);
  endtask

  task automatic t_level_only();
    start_op(8'hE2, 1'b1);
    chk("R7 bit1 no effect speaker", spk_en, 1);
    tick(1);
    chk("R12 advancing", seg_ptr, 1);
    cs_n = 1'b1; cyc();
    chk("R12 ends on select high", play_act, 0);
    chk("R12 no pulse", eom_n, 1);
    idle(2);
  endtask

  task automatic t_rerecord();
    start_op(8'd5, 1'b0);
    tick(9);
    cs_n = 1'b1; cyc();
    idle(5);
    start_op(8'd10, 1'b1);
    tick(3);
    chk("R14 stale marker cleared", seg_ptr, 13);
    chk("R14 still playing", play_act, 1);
    tick(1);
    tick(1);
    chk("R14 ends at new marker", play_act, 0);
    chk("R14 end pointer", seg_ptr, 14);
    cs_n = 1'b1; idle(6);
  endtask

  task automatic t_consecutive();
    pdown();
    start_op(8'hD0, 1'b0);
    chk("R10 first at 0", seg_ptr, 0);
    tick(2);
    cs_n = 1'b1; cyc(); idle(5);
    start_op(8'hD0, 1'b0);
    chk("R10 second follows first", seg_ptr, 3);
    tick(1);
    cs_n = 1'b1; cyc(); idle(5);
    start_op(8'hD0, 1'b1);
    chk("R10 direction change to 0", seg_ptr, 0);
    tick(3);
    chk("R10 playback ends at first marker", play_act, 0);
    cs_n = 1'b1; idle(6);
  endtask

  task automatic t_cue();
    start_op(8'hD1, 1'b1);
    chk("R11 cue starts after message", seg_ptr, 3);
    chk("R11 cue active", play_act, 1);
    chk("R11 speaker off", spk_en, 0);
    tick(1);
    chk("R11 advancing quietly", spk_en, 0);
    tick(1);
    chk("R11 halts", play_act, 0);
    chk("R11 rests on marker", seg_ptr, 4);
    cs_n = 1'b1; idle(6);
  endtask

  task automatic t_overflow_rec();
    start_op(8'd158, 1'b0);
    tick(1);
    chk("R6 at last segment", seg_ptr, 159);
    tick(1);
    chk("R6 record stops", rec_act, 0);
    chk("R6 eom low", eom_n, 0);
    chk("R13 aux during overflow", aux_sel, 1);
    idle(8);
    chk("R6 eom held", eom_n, 0);
    start_op(8'd10, 1'b1);
    chk("R6 edge ignored", play_act, 0);
    chk("R6 ptr kept", seg_ptr, 159);
    cs_n = 1'b1;
    pdown();
    chk("R1 pdown ptr", seg_ptr, 0);
    chk("R1 pdown eom", eom_n, 1);
  endtask

  task automatic t_overflow_play();
    start_op(8'd158, 1'b1);
    tick(2);
    chk("R6 play overflow stop", play_act, 0);
    chk("R6 play overflow eom", eom_n, 0);
    idle(6);
    chk("R6 play overflow held", eom_n, 0);
    cs_n = 1'b1;
    pdown();
    chk("R1 pdown clears lock", eom_n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwr_down = 1'b0; cs_n = 1'b1; play_sel = 1'b0;
    addr = 8'd0; seg_tick = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_record_direct();
    t_play_direct();
    t_out_of_range();
    t_cascade();
    t_loop_level();
    t_level_only();
    t_rerecord();
    t_consecutive();
    t_cue();
    t_overflow_rec();
    t_overflow_play();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule